// File: doc/BRIEF.md
# Dual-Reload Timer PWM Generator

This block is a programmable timer that produces one PWM output. The output period is split into a high phase and a low phase, and each phase has its own reload value. One down-counter serves both phases. It loads the high reload when the high phase starts and loads the low reload when the high phase ends. A second down-counter, the ON counter, runs beside the main counter with its own reload value. It can be slowed by a divide-by-ten prescaler, and that prescaler has no effect on the main counter.

Software reaches the block through a small word-addressed register port. Writes set the control word and the three reload values. Reads of a reload address do not return the stored value. They return the live counter behind it, which lets software follow the timer while it runs. The block does not generate clocks. The fast and slow sources come in as single-cycle tick strobes. A control bit picks which strobe advances the timer. In the gated output mode, the high phase carries a square wave that toggles on every fast tick, so it runs at half the fast rate, instead of a steady 1.

Top module: `dual_reload_pwm`

## Requirements
- R1: After reset every register is zero, every read address returns 0 and `pwm_out` is 0.
- R2: While control bit 0 (run) is 0, both counters and the prescaler are held at zero, the half-rate toggle is cleared, `pwm_out` is 0 and reads of addresses 1, 2 and 3 return 0.
- R3: Control bit 1 selects the timer tick: 1 uses `fast_tick`, 0 uses `slow_tick`. All phase lengths are counted in ticks of the selected source.
- R4: After run is set, the first tick starts a high phase. A high phase with reload H lasts H+1 ticks and a low phase with reload L lasts L+1 ticks. The two phases alternate without a gap.
- R5: With control bit 3 at 0, `pwm_out` is a steady 1 for the whole high phase and 0 for the whole low phase.
- R6: With control bit 3 at 1, `pwm_out` in the high phase follows a toggle that flips on every `fast_tick`. During the low phase it is 0.
- R7: The ON counter loads its reload (written at address 1) on an ON tick when it is zero. On every other ON tick it decrements. A read of address 1 returns its current value.
- R8: Control bit 2 at 1 makes every selected tick an ON tick. Bit 2 at 0 makes only every tenth selected tick an ON tick. Bit 2 never changes the main counter's phase lengths.
- R9: A read of address 2 (high reload) or address 3 (low reload) returns the current main counter value. A read of address 0 returns the control word in bits 3:0.
- R10: A reload value written while the timer runs takes effect at the next load of that phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_tick | input | 1 | One-cycle strobe from the fast time base |
| slow_tick | input | 1 | One-cycle strobe from the slow time base |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (2) | Word address: 0 control, 1 ON reload, 2 high reload, 3 low reload |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Read data for `addr`, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
The divide-by-ten path is the hardest to reach. Its effect is only visible as the spacing of ON counter changes, and it depends on where the prescaler stands when run is set. The bench stops the timer first, which clears the prescaler. It then starts the timer with a large ON reload and a tick on every cycle, and reads address 1 every cycle. This pins the first change to the tenth tick and every later change ten cycles apart. The gated mode cannot be checked by run lengths. Instead, the bench counts the ones in `pwm_out` over exactly one period and requires that no two consecutive samples are high.

// File: rtl/drt_pkg.sv
package drt_pkg;

   // Control word layout, bit 0 at the right.
   typedef struct packed {
      logic mode_gated;   // bit 3: high phase carries half-rate fast toggle
      logic div_bypass;   // bit 2: 1 = ON counter uses tick as is
      logic src_fast;     // bit 1: 1 = fast tick, 0 = slow tick
      logic run;          // bit 0: 1 = counting, 0 = held clear
   } drt_ctrl_t;

   localparam int unsigned CTRL_W = $bits(drt_ctrl_t);

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_ON   = 2'd1;
   localparam logic [1:0] ADR_HIGH = 2'd2;
   localparam logic [1:0] ADR_LOW  = 2'd3;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } drt_phase_e;

endpackage

// File: rtl/drt_regs.sv
module drt_regs
   import drt_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  main_cnt,
   input  logic [CNT_W-1:0]  on_cnt,
   output drt_ctrl_t         ctrl,
   output logic [CNT_W-1:0]  on_rl,
   output logic [CNT_W-1:0]  high_rl,
   output logic [CNT_W-1:0]  low_rl,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned PAD_W = DATA_W - CNT_W;
   localparam int unsigned CPAD  = DATA_W - CTRL_W;

   if (CNT_W > DATA_W) begin : g_chk_w
      $error("drt_regs: CNT_W must not exceed DATA_W");
   end
   if (ADDR_W != 2) begin : g_chk_a
      $error("drt_regs: register map needs ADDR_W of 2");
   end

   logic [1:0] sel;
   assign sel = addr[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl    <= '0;
         on_rl   <= '0;
         high_rl <= '0;
         low_rl  <= '0;
      end else if (wr_en) begin
         unique case (sel)
            ADR_CTRL: ctrl    <= drt_ctrl_t'(wdata[CTRL_W-1:0]);
            ADR_ON:   on_rl   <= wdata[CNT_W-1:0];
            ADR_HIGH: high_rl <= wdata[CNT_W-1:0];
            default:  low_rl  <= wdata[CNT_W-1:0];
         endcase
      end
   end

   // Reads of reload addresses show live counters.
   logic [DATA_W-1:0] main_x, on_x, ctrl_x;

   if (PAD_W == 0) begin : g_nopad
      assign main_x = main_cnt;
      assign on_x   = on_cnt;
   end else begin : g_pad
      assign main_x = {{PAD_W{1'b0}}, main_cnt};
      assign on_x   = {{PAD_W{1'b0}}, on_cnt};
   end
   assign ctrl_x = {{CPAD{1'b0}}, ctrl};

   always_comb begin
      unique case (sel)
         ADR_CTRL: rdata = ctrl_x;
         ADR_ON:   rdata = on_x;
         default:  rdata = main_x;
      endcase
   end

endmodule

// File: rtl/drt_prescale.sv
module drt_prescale #(
   parameter int unsigned DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic bypass,
   output logic on_tick
);

   if (DIV < 1) begin : g_chk
      $error("drt_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_direct
      assign on_tick = tick;
   end else begin : g_divide
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] pre;

      always_ff @(posedge clk) begin
         if (!rst_n || !run) begin
            pre <= '0;
         end else if (tick) begin
            pre <= (pre == LAST) ? '0 : pre + 1'b1;
         end
      end

      assign on_tick = bypass ? tick : (tick && pre == LAST);

      p_pre_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
         pre <= LAST);
      p_pre_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> pre == '0);
   end

endmodule

// File: rtl/drt_phase_ctr.sv
module drt_phase_ctr
   import drt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] high_rl,
   input  logic [CNT_W-1:0] low_rl,
   output logic [CNT_W-1:0] cnt,
   output drt_phase_e       phase
);

   if (CNT_W < 2) begin : g_chk
      $error("drt_phase_ctr: CNT_W must be at least 2");
   end

   logic at_zero;
   assign at_zero = (cnt == '0);

   // Stopped state is low phase at zero, so the first tick opens a high phase.
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt   <= '0;
         phase <= PH_LOW;
      end else if (tick) begin
         if (at_zero) begin
            if (phase == PH_HIGH) begin
               phase <= PH_LOW;
               cnt   <= low_rl;
            end else begin
               phase <= PH_HIGH;
               cnt   <= high_rl;
            end
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   p_stop_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0 && phase == PH_LOW));
   p_high_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && phase == PH_LOW && at_zero) |=>
         (phase == PH_HIGH && cnt == $past(high_rl)));
   p_low_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && phase == PH_HIGH && at_zero) |=>
         (phase == PH_LOW && cnt == $past(low_rl)));
   p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !at_zero) |=> cnt == $past(cnt) - 1'b1);
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> ($stable(cnt) && $stable(phase)));

endmodule

// File: rtl/drt_on_ctr.sv
module drt_on_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             on_tick,
   input  logic [CNT_W-1:0] on_rl,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
      end else if (on_tick) begin
         cnt <= (cnt == '0) ? on_rl : cnt - 1'b1;
      end
   end

   p_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);
   p_on_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && on_tick && cnt == '0) |=> cnt == $past(on_rl));
   p_on_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !on_tick) |=> $stable(cnt));

endmodule

// File: rtl/dual_reload_pwm.sv
module dual_reload_pwm
   import drt_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned ON_DIV = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_tick,
   input  logic              slow_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              pwm_out
);

   drt_ctrl_t        ctrl;
   logic [CNT_W-1:0] on_rl, high_rl, low_rl;
   logic [CNT_W-1:0] main_cnt, on_cnt;
   drt_phase_e       phase;
   logic             tick, on_tick, half;

   drt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .main_cnt(main_cnt), .on_cnt(on_cnt), .ctrl(ctrl), .on_rl(on_rl),
      .high_rl(high_rl), .low_rl(low_rl), .rdata(rdata)
   );

   assign tick = ctrl.src_fast ? fast_tick : slow_tick;

   drt_phase_ctr #(.CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick),
      .high_rl(high_rl), .low_rl(low_rl), .cnt(main_cnt), .phase(phase)
   );

   drt_prescale #(.DIV(ON_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick),
      .bypass(ctrl.div_bypass), .on_tick(on_tick)
   );

   drt_on_ctr #(.CNT_W(CNT_W)) u_on (
      .clk(clk), .rst_n(rst_n), .run(ctrl.run), .on_tick(on_tick),
      .on_rl(on_rl), .cnt(on_cnt)
   );

   // Half-rate fast toggle used as the high-phase carrier in gated mode.
   always_ff @(posedge clk) begin
      if (!rst_n || !ctrl.run) begin
         half <= 1'b0;
      end else if (fast_tick) begin
         half <= ~half;
      end
   end

   assign pwm_out = ctrl.run && (phase == PH_HIGH) &&
                    (ctrl.mode_gated ? half : 1'b1);

   p_low_phase_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOW) |-> !pwm_out);
   p_stopped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.run && !$past(ctrl.run)) |-> (!pwm_out && main_cnt == '0));
   p_reset_clear_r1: assert property (@(posedge clk)
      !$past(rst_n) |-> (rdata == '0 && !pwm_out));

endmodule

// File: tb/dual_reload_pwm_test.sv
`timescale 1ns/1ps
module dual_reload_pwm_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fast_tick = 1'b0;
   logic        slow_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        pwm_out;

   int total = 0;
   int bad = 0;
   int slow_per = 4;
   int cyc = 0;
   bit done = 0;

   dual_reload_pwm uut (
      .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
   );

   always #4 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         fast_tick = 1'b1;
         slow_tick = ((cyc % slow_per) == 0);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      addr = a;
      #1 v = int'(rdata);
   endtask

   task automatic measure(output int hi, output int lo);
      logic p, c;
      #1 p = pwm_out;
      forever begin
         @(negedge clk); #1 c = pwm_out;
         if (!p && c) break;
         p = c;
      end
      hi = 1;
      forever begin
         @(negedge clk); #1;
         if (pwm_out) hi++; else break;
      end
      lo = 1;
      forever begin
         @(negedge clk); #1;
         if (!pwm_out) lo++; else break;
      end
   endtask

   initial begin
      #800000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v, hi, lo, ones, run1, maxrun, prev, errs, nchg;
      int chg[3];
      int chgv[3];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk(v == 0, "R1 read after reset", v, 0);
      end
      #1 chk(pwm_out == 1'b0, "R1 pwm after reset", int'(pwm_out), 0);

      // R4/R5: sweep high and low reloads, fast source, steady output
      for (int h = 0; h < 4; h++) begin
         for (int l = 0; l < 4; l++) begin
            wr(2'd0, 0);
            wr(2'd2, h);
            wr(2'd3, l);
            wr(2'd0, 7);
            measure(hi, lo);
            chk(hi == h + 1, "R4/R5 high width", hi, h + 1);
            chk(lo == l + 1, "R4 low width", lo, l + 1);
         end
      end

      // R3: slow source, one tick every 4 cycles
      wr(2'd0, 0);
      wr(2'd2, 1);
      wr(2'd3, 2);
      wr(2'd0, 5);
      measure(hi, lo);
      chk(hi == 8, "R3 slow high width", hi, 8);
      chk(lo == 12, "R3 slow low width", lo, 12);
      wr(2'd0, 7);
      measure(hi, lo);
      chk(hi == 2, "R3 fast high width", hi, 2);
      chk(lo == 3, "R3 fast low width", lo, 3);

      // R6: gated mode, period 20 cycles with 8-cycle high phase
      wr(2'd0, 13);
      repeat (30) @(negedge clk);
      ones = 0; run1 = 0; maxrun = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #1;
         if (pwm_out) begin ones++; run1++; if (run1 > maxrun) maxrun = run1; end
         else run1 = 0;
      end
      chk(ones == 4, "R6 gated ones per period", ones, 4);
      chk(maxrun == 1, "R6 gated longest high run", maxrun, 1);

      // R2: stop clears output and counters
      wr(2'd0, 0);
      ones = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); #1;
         if (pwm_out) ones++;
      end
      chk(ones == 0, "R2 pwm while stopped", ones, 0);
      rd(2'd2, v); chk(v == 0, "R2 main counter stopped", v, 0);
      rd(2'd1, v); chk(v == 0, "R2 on counter stopped", v, 0);

      // R7: ON counter reload and decrement, no prescale
      wr(2'd1, 5);
      wr(2'd0, 7);
      addr = 2'd1;
      #1 prev = int'(rdata);
      errs = 0; maxrun = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk); #1 v = int'(rdata);
         if (v != ((prev == 0) ? 5 : prev - 1)) errs++;
         if (v > maxrun) maxrun = v;
         prev = v;
      end
      chk(errs == 0, "R7 on counter sequence errors", errs, 0);
      chk(maxrun == 5, "R7 on counter peak", maxrun, 5);

      // R8: divide by ten on the ON counter only
      wr(2'd0, 0);
      wr(2'd1, 200);
      wr(2'd2, 1);
      wr(2'd3, 1);
      wr(2'd0, 3);
      addr = 2'd1;
      #1 prev = int'(rdata);
      nchg = 0;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk); #1 v = int'(rdata);
         if (v != prev && nchg < 3) begin chg[nchg] = i; chgv[nchg] = v; nchg++; end
         prev = v;
      end
      chk(nchg == 3, "R8 change count", nchg, 3);
      chk(chg[0] == 10, "R8 first ON tick", chg[0], 10);
      chk(chg[1] - chg[0] == 10, "R8 ON tick spacing", chg[1] - chg[0], 10);
      chk(chg[2] - chg[1] == 10, "R8 ON tick spacing 2", chg[2] - chg[1], 10);
      chk(chgv[0] == 200, "R8 first load value", chgv[0], 200);
      chk(chgv[1] == 199, "R8 decrement value", chgv[1], 199);
      measure(hi, lo);
      chk(hi == 2, "R8 main high unaffected", hi, 2);
      chk(lo == 2, "R8 main low unaffected", lo, 2);

      // R9: main counter readback and control readback
      wr(2'd0, 0);
      wr(2'd2, 6);
      wr(2'd3, 6);
      wr(2'd0, 7);
      rd(2'd0, v); chk(v == 7, "R9 control readback", v, 7);
      addr = 2'd2;
      #1 prev = int'(rdata);
      errs = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk); #1 v = int'(rdata);
         if (v != ((prev == 0) ? 6 : prev - 1)) errs++;
         prev = v;
      end
      chk(errs == 0, "R9 main counter sequence errors", errs, 0);
      rd(2'd3, v);
      chk(v == ((prev == 0) ? 6 : prev - 1), "R9 low address shows counter", v,
          (prev == 0) ? 6 : prev - 1);

      // R10: reload change while running
      wr(2'd0, 0);
      wr(2'd2, 2);
      wr(2'd3, 1);
      wr(2'd0, 7);
      measure(hi, lo);
      chk(hi == 3, "R10 high before change", hi, 3);
      wr(2'd2, 5);
      measure(hi, lo);
      chk(hi == 6, "R10 high after change", hi, 6);
      chk(lo == 2, "R10 low unchanged", lo, 2);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule